// File: doc/BRIEF.md
# Instruction Cycle Sequencer for RAM-Resident Registers

This block steps a small processor through one instruction at a time when that processor has no register file. Every architectural register, the status word among them, lives at a fixed address in one single-port synchronous RAM. Each register access is therefore a bus cycle of its own. The sequencer takes one already-decoded instruction descriptor over a valid/ready handshake. It then runs only the machine cycles that the instruction's kind needs: fetch, status read, operand reads, memory read, status write, instruction-pointer save, result write and memory store. It raises `done` for one clock at the end.

Registers are named by a 6-bit id: bits [5:4] give the group (0 = A, 1 = B, 2 = C, 3 = D) and bits [3:0] give the index 0..9. The register at id (g, i) lives at RAM address `REG_PAGE*2^DW + g*10 + i`. The status word is A0. The saved instruction pointer goes to the pair B0 (high byte) and C0 (low byte). The ALU is outside the block and combinational. The sequencer presents the operation code, two operands and the current status word, and takes back a result and a new status word in the same cycle.

The input side obeys valid/ready. `in_ready` is high only while the sequencer is idle. A descriptor is taken on the edge where `in_valid` and `in_ready` are both high. While an instruction runs, `in_ready` stays low, so upstream must hold its descriptor until it is taken. The fields are sampled only at the handshake.

Top module: `memreg_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `ram_we` is 0.
- R2: A descriptor is accepted only on an edge with `in_valid` and `in_ready` both high. `in_ready` then stays 0 until the instruction ends, and `in_valid` during that time has no effect. The first cycle after acceptance reads RAM at `in_ip`, and that byte is shown on `ins_code` from the third cycle through `done`.
- R3: Register id bits [5:4] (group) and [3:0] (index) map to RAM address `{REG_PAGE, group*10+index}`. A0 is the status word, B0 and C0 hold the saved instruction pointer.
- R4: Kinds 0 (register) and 1 (load) read A0 in the cycle right after fetch, before any operand. They write A0 with `alu_psw_out` one cycle after the last read data has arrived.
- R5: Kind 0 reads the right operand (`in_src`) and then the left operand (`in_dst`). The ALU gets a = left, b = right and the status word read before. `alu_res` is written to `in_dst`.
- R6: Kind 1 reads the offset counter (`in_src`), then the base (`in_base`), then RAM at `({base,counter} + in_disp) mod 2^(2*DW)`. The ALU gets a = 0 and b = that byte, and the result goes to `in_dst`.
- R7: Kind 2 (store) reads the counter, then the base, then register `in_dst`, and writes that byte to the address computed as in R6. It neither reads nor writes A0.
- R8: Kind 3 (call/halt) writes `in_ip` low byte to C0 and then the high byte to B0, in two consecutive cycles right after fetch.
- R9: Cycles not needed by a kind are skipped. From the fetch cycle through the `done` cycle, kind 0 takes 8 cycles, kind 1 takes 9, kind 2 takes 6 and kind 3 takes 4, and no kind exceeds 18.
- R10: `done` is 1 for exactly one clock, right after the final bus cycle, and `in_ready` returns to 1 on the next clock.
- R11: `ram_we` is 1 only in write cycles, never while idle nor in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Sequencer idle, descriptor can be taken |
| in_kind | input | 2 | 0 register, 1 load, 2 store, 3 call/halt |
| in_op | input | 3 | ALU operation code, passed through unchanged |
| in_dst | input | 6 | Receiver register id (store: data register) |
| in_src | input | 6 | Right operand id or offset counter id |
| in_base | input | 6 | Base register id for memory kinds |
| in_disp | input | DW | Displacement added to the memory address |
| in_ip | input | 2*DW | Instruction pointer of this instruction |
| ram_addr | output | 2*DW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DW | RAM read data, one cycle after its address |
| alu_op | output | 3 | Operation code to the ALU |
| alu_a | output | DW | ALU left operand |
| alu_b | output | DW | ALU right operand |
| alu_psw_in | output | DW | Status word given to the ALU |
| alu_res | input | DW | ALU result |
| alu_psw_out | input | DW | Status word returned by the ALU |
| ins_code | output | DW | Byte read in the fetch cycle |
| done | output | 1 | One-clock end-of-instruction strobe |

## Verification
The assertions take for granted that the RAM returns read data exactly one cycle after the address, that the ALU answers in the same cycle, and that the upstream side obeys valid/ready without expecting a descriptor to be taken while busy. The stimulus drives every descriptor on the falling edge and models the RAM with a one-cycle read. It picks operands so that no instruction writes a location it reads later in the same instruction. Its ALU is combinational. It also raises `in_valid` with stray fields during one busy run, which must change nothing.

// File: rtl/memreg_pkg.sv
package memreg_pkg;

  typedef enum logic [1:0] {
    K_REG   = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_CALL  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_RPSW, S_RRGT, S_RLFT, S_RMEM, S_EXEC,
    S_WPSW, S_WIPL, S_WIPH, S_WRES, S_WMEM, S_DONE
  } st_e;

  // Which read (if any) was issued in a cycle; data lands one cycle later.
  typedef enum logic [2:0] {
    T_NONE = 3'd0,
    T_CODE = 3'd1,
    T_PSW  = 3'd2,
    T_RGT  = 3'd3,
    T_LFT  = 3'd4,
    T_MEM  = 3'd5
  } tag_e;

  localparam int NSLOT = 5;
  localparam int IDW   = 6;

endpackage

// File: rtl/memreg_regmap.sv
module memreg_regmap #(
  parameter int DW = 8,
  parameter logic [DW-1:0] REG_PAGE = '1
) (
  input  logic [5:0]      id,
  output logic [2*DW-1:0] addr
);
  logic [DW-1:0] slot;
  always_comb begin
    slot = DW'(id[5:4]) * DW'(10) + DW'(id[3:0]);
    addr = {REG_PAGE, slot};
  end
endmodule

// File: rtl/memreg_fsm.sv
module memreg_fsm
  import memreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  kind_e kind,
  output st_e   st
);
  st_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:  if (start) nxt = S_FETCH;
      S_FETCH: begin
        if (kind == K_CALL)       nxt = S_WIPL;
        else if (kind == K_STORE) nxt = S_RRGT;
        else                      nxt = S_RPSW;
      end
      S_RPSW:  nxt = S_RRGT;
      S_RRGT:  nxt = S_RLFT;
      S_RLFT:  nxt = (kind == K_REG) ? S_EXEC : S_RMEM;
      S_RMEM:  nxt = (kind == K_STORE) ? S_WMEM : S_EXEC;
      S_EXEC:  nxt = S_WPSW;
      S_WPSW:  nxt = S_WRES;
      S_WRES:  nxt = S_DONE;
      S_WIPL:  nxt = S_WIPH;
      S_WIPH:  nxt = S_DONE;
      S_WMEM:  nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/memreg_capture.sv
module memreg_capture
  import memreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  tag_e                     tag_now,
  input  logic [DW-1:0]            rdata,
  output logic [NSLOT-1:0][DW-1:0] slots
);
  tag_e tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= T_NONE;
    else        tag_q <= tag_now;
  end

  // slot k holds the data of the read tagged k+1
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       slots[k] <= '0;
      else if (tag_q == tag_e'(k + 1))  slots[k] <= rdata;
    end
  end
endmodule

// File: rtl/memreg_seq.sv
module memreg_seq
  import memreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] REG_PAGE = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_kind,
  input  logic [2:0]      in_op,
  input  logic [5:0]      in_dst,
  input  logic [5:0]      in_src,
  input  logic [5:0]      in_base,
  input  logic [DW-1:0]   in_disp,
  input  logic [2*DW-1:0] in_ip,
  output logic [2*DW-1:0] ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  input  logic [DW-1:0]   ram_rdata,
  output logic [2:0]      alu_op,
  output logic [DW-1:0]   alu_a,
  output logic [DW-1:0]   alu_b,
  output logic [DW-1:0]   alu_psw_in,
  input  logic [DW-1:0]   alu_res,
  input  logic [DW-1:0]   alu_psw_out,
  output logic [DW-1:0]   ins_code,
  output logic            done
);
  localparam int AW    = 2 * DW;
  localparam int NMAP  = 6;
  localparam int M_DST = 0, M_SRC = 1, M_BASE = 2, M_PSW = 3, M_B0 = 4, M_C0 = 5;

  st_e   st;
  tag_e  tag_now;
  kind_e kind_q;
  logic  start;
  logic [2:0]    op_q;
  logic [5:0]    dst_q, src_q, base_q;
  logic [DW-1:0] disp_q, res_q;
  logic [AW-1:0] ip_q;
  logic [NSLOT-1:0][DW-1:0] cap;
  logic [NMAP-1:0][5:0]     map_id;
  logic [NMAP-1:0][AW-1:0]  map_addr;
  logic [DW-1:0] code_v, psw_v, rgt_v, lft_v, mem_v;

  assign start    = in_valid && in_ready;
  assign in_ready = (st == S_IDLE);
  assign done     = (st == S_DONE);

  // descriptor is held for the whole instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_REG;
      op_q   <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      base_q <= '0;
      disp_q <= '0;
      ip_q   <= '0;
    end else if (start) begin
      kind_q <= kind_e'(in_kind);
      op_q   <= in_op;
      dst_q  <= in_dst;
      src_q  <= in_src;
      base_q <= in_base;
      disp_q <= in_disp;
      ip_q   <= in_ip;
    end
  end

  memreg_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .kind  (kind_q),
    .st    (st)
  );

  // register-to-address translation, one mapper per register reference
  assign map_id[M_DST]  = dst_q;
  assign map_id[M_SRC]  = src_q;
  assign map_id[M_BASE] = base_q;
  assign map_id[M_PSW]  = 6'h00;
  assign map_id[M_B0]   = 6'h10;
  assign map_id[M_C0]   = 6'h20;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    memreg_regmap #(.DW(DW), .REG_PAGE(REG_PAGE)) u_map (
      .id   (map_id[m]),
      .addr (map_addr[m])
    );
  end

  always_comb begin
    unique case (st)
      S_FETCH: tag_now = T_CODE;
      S_RPSW:  tag_now = T_PSW;
      S_RRGT:  tag_now = T_RGT;
      S_RLFT:  tag_now = T_LFT;
      S_RMEM:  tag_now = T_MEM;
      default: tag_now = T_NONE;
    endcase
  end

  memreg_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_now (tag_now),
    .rdata   (ram_rdata),
    .slots   (cap)
  );

  assign code_v = cap[int'(T_CODE) - 1];
  assign psw_v  = cap[int'(T_PSW)  - 1];
  assign rgt_v  = cap[int'(T_RGT)  - 1];
  assign lft_v  = cap[int'(T_LFT)  - 1];
  assign mem_v  = cap[int'(T_MEM)  - 1];
  assign ins_code = code_v;

  // ALU side
  assign alu_op     = op_q;
  assign alu_psw_in = psw_v;
  assign alu_a      = (kind_q == K_LOAD) ? '0 : lft_v;
  assign alu_b      = (kind_q == K_LOAD) ? mem_v : rgt_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             res_q <= '0;
    else if (st == S_WPSW)  res_q <= alu_res;
  end

  // RAM bus; the load's base byte is still on ram_rdata in its memory cycle
  always_comb begin
    ram_addr  = '0;
    ram_wdata = '0;
    ram_we    = 1'b0;
    unique case (st)
      S_FETCH: ram_addr = ip_q;
      S_RPSW:  ram_addr = map_addr[M_PSW];
      S_RRGT:  ram_addr = map_addr[M_SRC];
      S_RLFT:  ram_addr = (kind_q == K_REG) ? map_addr[M_DST] : map_addr[M_BASE];
      S_RMEM:  ram_addr = (kind_q == K_LOAD) ? ({ram_rdata, rgt_v} + AW'(disp_q))
                                             : map_addr[M_DST];
      S_WPSW: begin
        ram_addr  = map_addr[M_PSW];
        ram_wdata = alu_psw_out;
        ram_we    = 1'b1;
      end
      S_WIPL: begin
        ram_addr  = map_addr[M_C0];
        ram_wdata = ip_q[DW-1:0];
        ram_we    = 1'b1;
      end
      S_WIPH: begin
        ram_addr  = map_addr[M_B0];
        ram_wdata = ip_q[AW-1:DW];
        ram_we    = 1'b1;
      end
      S_WRES: begin
        ram_addr  = map_addr[M_DST];
        ram_wdata = res_q;
        ram_we    = 1'b1;
      end
      S_WMEM: begin
        ram_addr  = {lft_v, rgt_v} + AW'(disp_q);
        ram_wdata = ram_rdata;
        ram_we    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/memreg_seq_chk.sv
module memreg_seq_chk #(
  parameter int DW = 8,
  parameter int MAXT = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2*DW-1:0] in_ip,
  input logic [2*DW-1:0] ram_addr,
  input logic            ram_we,
  input logic            done
);
  logic [5:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cyc <= '0;
    else if (in_valid && in_ready) cyc <= '0;
    else if (!in_ready && cyc != 6'h3f) cyc <= cyc + 6'd1;
  end

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!ram_we && ram_addr == $past(in_ip)));

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  p_we_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!in_ready && !done));

  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(cyc) < MAXT));
endmodule

bind memreg_seq memreg_seq_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_ip    (in_ip),
  .ram_addr (ram_addr),
  .ram_we   (ram_we),
  .done     (done)
);

// File: tb/memreg_seq_tb.sv
module memreg_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = '0;
  logic [2:0]  in_op = '0;
  logic [5:0]  in_dst = '0, in_src = '0, in_base = '0;
  logic [7:0]  in_disp = '0;
  logic [15:0] in_ip = '0;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata, alu_a, alu_b, alu_psw_in, alu_res, alu_psw_out, ins_code;
  logic        ram_we, done;
  logic [2:0]  alu_op;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] mem [0:65535];

  memreg_seq dut_i (.*);

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic void alu_f(input logic [2:0] op, input logic [7:0] a, b, p,
                                output logic [7:0] r, output logic [7:0] f);
    logic [8:0] w;
    case (op)
      3'd0: w = {1'b0, a} + {1'b0, b};
      3'd1: w = {1'b0, a} - {1'b0, b};
      3'd2: w = {1'b0, a & b};
      3'd3: w = {1'b0, a | b};
      3'd4: w = {1'b0, a ^ b};
      default: w = {1'b0, b};
    endcase
    r = w[7:0];
    f = (p & 8'hF4) | {4'h0, r[7], 1'b0, w[8], (r == 8'h00)};
  endfunction

  always_comb alu_f(alu_op, alu_a, alu_b, alu_psw_in, alu_res, alu_psw_out);

  function automatic logic [15:0] ra(input logic [5:0] id);
    return 16'hFF00 | 16'(id[5:4] * 10 + id[3:0]);
  endfunction

  logic [15:0] qa[$];
  bit          qca[$], qwe[$], qdn[$];
  logic [7:0]  qwd[$];
  string       qrq[$];

  function automatic void push(logic [15:0] a, bit ca, bit we, logic [7:0] wd, bit dn, string rq);
    qa.push_back(a); qca.push_back(ca); qwe.push_back(we);
    qwd.push_back(wd); qdn.push_back(dn); qrq.push_back(rq);
  endfunction

  task automatic chk(bit ok, string rq, string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic [2:0] op, input logic [5:0] d, s, b,
                     input logic [7:0] disp, input logic [15:0] ip, input bit poke);
    logic [7:0] r, f, code;
    logic [15:0] ma;
    code = mem[ip];
    push(ip, 1, 0, 0, 0, "R2 fetch");
    case (k)
      2'd0: begin
        push(ra(0), 1, 0, 0, 0, "R4 status read");
        push(ra(s), 1, 0, 0, 0, "R3 R5 right operand");
        push(ra(d), 1, 0, 0, 0, "R5 left operand");
        push(0, 0, 0, 0, 0, "R9 capture cycle");
        alu_f(op, mem[ra(d)], mem[ra(s)], mem[ra(0)], r, f);
        push(ra(0), 1, 1, f, 0, "R4 status write");
        push(ra(d), 1, 1, r, 0, "R5 result write");
      end
      2'd1: begin
        push(ra(0), 1, 0, 0, 0, "R4 status read");
        push(ra(s), 1, 0, 0, 0, "R6 counter read");
        push(ra(b), 1, 0, 0, 0, "R6 base read");
        ma = {mem[ra(b)], mem[ra(s)]} + 16'(disp);
        push(ma, 1, 0, 0, 0, "R6 memory read");
        push(0, 0, 0, 0, 0, "R9 capture cycle");
        alu_f(op, 8'h00, mem[ma], mem[ra(0)], r, f);
        push(ra(0), 1, 1, f, 0, "R4 status write");
        push(ra(d), 1, 1, r, 0, "R6 result write");
      end
      2'd2: begin
        push(ra(s), 1, 0, 0, 0, "R7 counter read");
        push(ra(b), 1, 0, 0, 0, "R7 base read");
        push(ra(d), 1, 0, 0, 0, "R7 data read");
        ma = {mem[ra(b)], mem[ra(s)]} + 16'(disp);
        push(ma, 1, 1, mem[ra(d)], 0, "R7 store");
      end
      default: begin
        push(ra(6'h20), 1, 1, ip[7:0], 0, "R8 low byte to C0");
        push(ra(6'h10), 1, 1, ip[15:8], 0, "R8 high byte to B0");
      end
    endcase
    push(0, 0, 0, 0, 1, "R10 done strobe");

    @(negedge clk);
    chk(in_ready == 1'b1, "R2", $sformatf("in_ready act %0b exp 1", in_ready));
    in_valid = 1; in_kind = k; in_op = op; in_dst = d; in_src = s; in_base = b;
    in_disp = disp; in_ip = ip;
    for (int i = 0; qa.size() > 0; i++) begin
      logic [15:0] ea; bit eca, ewe, edn; logic [7:0] ewd; string rq;
      @(negedge clk);
      if (i == 0) begin
        // R2: stray valid with other fields while busy must be ignored
        if (poke) begin in_kind = 2'd3; in_ip = 16'hDEAD; in_dst = 6'h01; end
        else in_valid = 0;
      end else if (i == 1) in_valid = 0;
      ea = qa.pop_front(); eca = qca.pop_front(); ewe = qwe.pop_front();
      ewd = qwd.pop_front(); edn = qdn.pop_front(); rq = qrq.pop_front();
      chk(ram_we == ewe, rq, $sformatf("ram_we act %0b exp %0b", ram_we, ewe));
      chk(done == edn, rq, $sformatf("done act %0b exp %0b", done, edn));
      chk(in_ready == 1'b0, rq, $sformatf("in_ready act %0b exp 0", in_ready));
      if (eca) chk(ram_addr == ea, rq, $sformatf("ram_addr act %h exp %h", ram_addr, ea));
      if (ewe) chk(ram_wdata == ewd, rq, $sformatf("ram_wdata act %h exp %h", ram_wdata, ewd));
    end
    chk(ins_code == code, "R2", $sformatf("ins_code act %h exp %h", ins_code, code));
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", $sformatf("in_ready after done act %0b exp 1", in_ready));
    chk(ram_we == 1'b0, "R11", $sformatf("idle ram_we act %0b exp 0", ram_we));
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1 && done == 1'b0 && ram_we == 1'b0, "R1",
        $sformatf("ready/done/we act %0b%0b%0b exp 100", in_ready, done, ram_we));
    rst_n = 1;
    @(negedge clk);
    mem[ra(6'h00)] = 8'h04;
    mem[ra(6'h01)] = 8'hF0; mem[ra(6'h12)] = 8'h20;
    run(2'd0, 3'd0, 6'h01, 6'h12, 6'h00, 8'h00, 16'h0100, 0);   // R5 add with carry
    mem[ra(6'h03)] = 8'h55; mem[ra(6'h37)] = 8'h55;
    run(2'd1 - 2'd1, 3'd1, 6'h03, 6'h37, 6'h00, 8'h00, 16'h0123, 1); // R4 zero, R2 stray valid
    mem[ra(6'h05)] = 8'h0F; mem[ra(6'h39)] = 8'h80;
    run(2'd0, 3'd4, 6'h05, 6'h39, 6'h00, 8'h00, 16'h0200, 0);   // sign flag
    mem[ra(6'h24)] = 8'h34; mem[ra(6'h16)] = 8'h12; mem[16'h123B] = 8'hA7;
    run(2'd1, 3'd5, 6'h01, 6'h24, 6'h16, 8'h07, 16'h0300, 0);   // R6 load
    mem[ra(6'h26)] = 8'hFE; mem[ra(6'h19)] = 8'h7F; mem[16'h8003] = 8'h00;
    run(2'd1, 3'd0, 6'h02, 6'h26, 6'h19, 8'h05, 16'h0310, 0);   // R6 carry into high byte
    mem[ra(6'h03)] = 8'h5A;
    run(2'd2, 3'd0, 6'h03, 6'h24, 6'h16, 8'h09, 16'h0400, 0);   // R7 store
    chk(mem[16'h123D] == 8'h5A, "R7", $sformatf("stored byte act %h exp 5a", mem[16'h123D]));
    run(2'd3, 3'd0, 6'h00, 6'h00, 6'h00, 8'h00, 16'h1247, 0);   // R8 call
    run(2'd0, 3'd2, 6'h01, 6'h12, 6'h00, 8'h00, 16'h0500, 0);   // R9 back to back
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9: watchdog expired, act running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule